// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level page table held in memory. An accepted request latches the virtual address and a root pointer. The engine then reads one entry from the top-level directory. That entry names a second-level table, and the engine reads one entry from it. The second entry supplies the frame number, which is joined with the untranslated low 12 bits of the address. Each table has 1024 entries of 4 bytes, so one table fills one 4 KB page.

An entry whose valid flag is clear stops the walk at once. The engine then answers with a fault that names the level where the walk stopped. All memory traffic goes through a single-beat read port. That port has a request handshake and a separate data-return strobe, and only one read is ever outstanding.

The request and response sides are valid/ready streams. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low for the whole walk, so a request offered during a walk waits and is not taken. Once `rsp_valid` rises, the result stays on the pins until `rsp_ready` is seen high. The memory read request follows the same hold rule against `mem_rd_ready`. `mem_data_valid` has no back-pressure and is taken in the cycle it is high.

Top module: `ptw_walker`

## Requirements
- R1: During and right after reset, `req_ready` is 1, and `mem_rd_valid` and `rsp_valid` are 0.
- R2: The first memory read of a walk goes to `root_base + vaddr[31:22]*4`, using the `root_base` value held at the acceptance edge. Later changes to `root_base` have no effect on that walk.
- R3: If the directory entry has bit 0 set, the second read goes to `{dir_entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: If the table entry has bit 0 set, the response carries `rsp_fault=0` and `rsp_paddr = {tbl_entry[31:12], vaddr[11:0]}`.
- R5: If the directory entry has bit 0 clear, no second read is made. The response carries `rsp_fault=1`, `rsp_fault_lvl=0` and `rsp_paddr=0`.
- R6: If the table entry has bit 0 clear, the response carries `rsp_fault=1`, `rsp_fault_lvl=1` and `rsp_paddr=0`.
- R7: `req_ready` is 0 from the acceptance edge until the response handshake completes. A request held valid in that window is not taken and does not change the walk in progress.
- R8: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request and its address hold steady.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_fault_lvl` hold steady.
- R10: At most one memory read is outstanding. `mem_rd_valid` stays low from a read handshake until the matching `mem_data_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_base | input | 32 | Physical address of the top-level directory, sampled on acceptance |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Walk hit an entry with the valid bit clear |
| rsp_fault_lvl | output | 1 | Level of the faulting entry: 0 directory, 1 table |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_data_valid | input | 1 | Read data returned this cycle |
| mem_data | input | 32 | Returned entry |

## Verification
The hardest case to reach is a walk whose inputs change while it is in flight. In that case the root pointer moves, a second request sits valid against a low `req_ready`, and both the read port and the response port apply back-pressure at the same time. The stimulus reaches it in three ways. It flips `root_base` on the cycle right after acceptance. It queues requests back to back so the next one is already valid while a walk runs. It draws `mem_rd_ready`, `rsp_ready` and the return latency from a pseudo-random sequence. Second-level faults also need a directory entry that is valid over a table entry that is not, so the memory image holds such a pair.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DIR_REQ,
    WS_DIR_WAIT,
    WS_TBL_REQ,
    WS_TBL_WAIT,
    WS_DONE,
    WS_FAULT
  } walk_st_t;

  localparam int unsigned LEVELS = 2;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned AW        = 32,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned ENT_SHIFT = 2
) (
  input  logic [AW-1:0]    tbl_base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    ent_addr
);
  localparam int unsigned PAD_W = AW - IDX_W - ENT_SHIFT;

  logic [AW-1:0] byte_off;

  assign byte_off = {{PAD_W{1'b0}}, idx, {ENT_SHIFT{1'b0}}};
  assign ent_addr = tbl_base + byte_off;
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int unsigned EW      = 32,
  parameter int unsigned FRAME_W = 20
) (
  input  logic [EW-1:0]      entry,
  output logic               present,
  output logic [FRAME_W-1:0] frame
);
  assign present = entry[0];
  assign frame   = entry[EW-1 -: FRAME_W];
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     mem_rd_ready,
  input  logic     mem_data_valid,
  input  logic     entry_ok,
  input  logic     rsp_ready,
  output walk_st_t state,
  output logic     req_ready,
  output logic     mem_rd_valid,
  output logic     rsp_valid,
  output logic     accept,
  output logic     dir_take,
  output logic     tbl_take
);
  walk_st_t nxt;

  assign req_ready    = (state == WS_IDLE);
  assign mem_rd_valid = (state == WS_DIR_REQ) || (state == WS_TBL_REQ);
  assign rsp_valid    = (state == WS_DONE) || (state == WS_FAULT);
  assign accept       = req_ready && req_valid;
  assign dir_take     = (state == WS_DIR_WAIT) && mem_data_valid;
  assign tbl_take     = (state == WS_TBL_WAIT) && mem_data_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      WS_IDLE:     if (req_valid)      nxt = WS_DIR_REQ;
      WS_DIR_REQ:  if (mem_rd_ready)   nxt = WS_DIR_WAIT;
      WS_DIR_WAIT: if (mem_data_valid) nxt = entry_ok ? WS_TBL_REQ : WS_FAULT;
      WS_TBL_REQ:  if (mem_rd_ready)   nxt = WS_TBL_WAIT;
      WS_TBL_WAIT: if (mem_data_valid) nxt = entry_ok ? WS_DONE : WS_FAULT;
      WS_DONE,
      WS_FAULT:    if (rsp_ready)      nxt = WS_IDLE;
      default:                         nxt = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WS_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned ENT_SHIFT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PA_W-1:0]               root_base,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [2*IDX_W+OFF_W-1:0]      req_vaddr,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [PA_W-1:0]               rsp_paddr,
  output logic                          rsp_fault,
  output logic                          rsp_fault_lvl,
  output logic                          mem_rd_valid,
  input  logic                          mem_rd_ready,
  output logic [PA_W-1:0]               mem_rd_addr,
  input  logic                          mem_data_valid,
  input  logic [PA_W-1:0]               mem_data
);
  localparam int unsigned VA_W    = 2*IDX_W + OFF_W;
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  walk_st_t        state;
  logic            accept, dir_take, tbl_take, entry_ok;
  logic [FRAME_W-1:0] entry_frame;

  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] root_q;
  logic [PA_W-1:0] tbl_q;
  logic [PA_W-1:0] paddr_q;
  logic            fault_q, lvl_q;

  logic [PA_W-1:0]  lvl_base [LEVELS];
  logic [IDX_W-1:0] lvl_idx  [LEVELS];
  logic [PA_W-1:0]  lvl_addr [LEVELS];

  ptw_walk_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .mem_rd_ready   (mem_rd_ready),
    .mem_data_valid (mem_data_valid),
    .entry_ok       (entry_ok),
    .rsp_ready      (rsp_ready),
    .state          (state),
    .req_ready      (req_ready),
    .mem_rd_valid   (mem_rd_valid),
    .rsp_valid      (rsp_valid),
    .accept         (accept),
    .dir_take       (dir_take),
    .tbl_take       (tbl_take)
  );

  ptw_entry_decode #(.EW(PA_W), .FRAME_W(FRAME_W)) u_dec (
    .entry   (mem_data),
    .present (entry_ok),
    .frame   (entry_frame)
  );

  assign lvl_base[0] = root_q;
  assign lvl_base[1] = tbl_q;

  // Level 0 takes the upper index field, level 1 the field below it.
  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      assign lvl_idx[g] = va_q[VA_W-1-g*IDX_W -: IDX_W];
      ptw_entry_addr #(.AW(PA_W), .IDX_W(IDX_W), .ENT_SHIFT(ENT_SHIFT)) u_addr (
        .tbl_base (lvl_base[g]),
        .idx      (lvl_idx[g]),
        .ent_addr (lvl_addr[g])
      );
    end
  endgenerate

  assign mem_rd_addr = (state == WS_TBL_REQ) ? lvl_addr[1] : lvl_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      if (accept) begin
        va_q    <= req_vaddr;
        root_q  <= root_base;
        fault_q <= 1'b0;
        lvl_q   <= 1'b0;
        paddr_q <= '0;
      end
      if (dir_take) begin
        if (entry_ok) begin
          tbl_q <= {entry_frame, {OFF_W{1'b0}}};
        end else begin
          fault_q <= 1'b1;
          lvl_q   <= 1'b0;
          paddr_q <= '0;
        end
      end
      if (tbl_take) begin
        if (entry_ok) begin
          paddr_q <= {entry_frame, va_q[OFF_W-1:0]};
          fault_q <= 1'b0;
        end else begin
          fault_q <= 1'b1;
          lvl_q   <= 1'b1;
          paddr_q <= '0;
        end
      end
    end
  end

  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = lvl_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned PA_W = 32,
  parameter int unsigned VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PA_W-1:0] root_base,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic            rsp_fault_lvl,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            mem_data_valid
);
  logic [PA_W-1:0] exp_dir;
  logic [11:0]     exp_off;
  logic [1:0]      rd_n;
  logic            pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_dir <= '0;
      exp_off <= '0;
      rd_n    <= '0;
      pending <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        exp_dir <= root_base + {req_vaddr[31:22], 2'b00};
        exp_off <= req_vaddr[11:0];
        rd_n    <= '0;
      end else if (mem_rd_valid && mem_rd_ready) begin
        rd_n <= rd_n + 2'd1;
      end
      if (mem_rd_valid && mem_rd_ready) pending <= 1'b1;
      else if (mem_data_valid)          pending <= 1'b0;
    end
  end

  p_dir_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && rd_n == 2'd0) |-> (mem_rd_addr == exp_dir));

  p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == exp_off));

  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_valid) |-> !req_ready);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_lvl)));

  p_one_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_rd_valid);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .VA_W(VA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .root_base      (root_base),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_vaddr      (req_vaddr),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_paddr      (rsp_paddr),
  .rsp_fault      (rsp_fault),
  .rsp_fault_lvl  (rsp_fault_lvl),
  .mem_rd_valid   (mem_rd_valid),
  .mem_rd_ready   (mem_rd_ready),
  .mem_rd_addr    (mem_rd_addr),
  .mem_data_valid (mem_data_valid)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_data_valid = 1'b0;
  logic [31:0] mem_data = '0;

  always #5 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_data_valid(mem_data_valid), .mem_data(mem_data)
  );

  int vectors = 0;
  int errors  = 0;

  logic [31:0] pmem [bit [31:0]];

  function automatic logic [31:0] mget(input logic [31:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference state
  bit          busy = 0;
  logic [31:0] exp_rd_q [$];
  logic [33:0] exp_rsp_q [$];
  string       exp_tag_q [$];
  bit          acc_flag = 0;
  bit          rd_fired = 0;
  logic [31:0] rd_fired_addr;

  // Stall knobs
  bit rd_stall = 0, rsp_stall = 0, lat_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready == !busy, "R7 req_ready", {33'b0, req_ready}, {33'b0, !busy});
      if (mem_rd_valid) begin
        if (exp_rd_q.size() == 0)
          check(1'b0, "R10 unexpected read", {2'b0, mem_rd_addr}, 34'h0);
        else begin
          check(mem_rd_addr == exp_rd_q[0], "R2/R3/R8 read address",
                {2'b0, mem_rd_addr}, {2'b0, exp_rd_q[0]});
          if (mem_rd_ready) begin
            rd_fired = 1;
            rd_fired_addr = mem_rd_addr;
            void'(exp_rd_q.pop_front());
          end
        end
      end
      if (rsp_valid) begin
        if (exp_rsp_q.size() == 0)
          check(1'b0, "R7 unexpected response", {rsp_fault, rsp_fault_lvl, rsp_paddr}, 34'h0);
        else begin
          check({rsp_fault, rsp_fault_lvl, rsp_paddr} == exp_rsp_q[0], exp_tag_q[0],
                {rsp_fault, rsp_fault_lvl, rsp_paddr}, exp_rsp_q[0]);
          if (rsp_ready) begin
            void'(exp_rsp_q.pop_front());
            void'(exp_tag_q.pop_front());
            busy = 0;
          end
        end
      end else if (busy && exp_rd_q.size() == 0 && exp_rsp_q.size() == 0) begin
        check(1'b0, "R9 response dropped", 34'h0, 34'h1);
      end
      if (req_valid && req_ready && !busy) begin
        logic [31:0] da, de, ta, te;
        busy = 1;
        acc_flag = 1;
        da = root_base + {20'b0, req_vaddr[31:22], 2'b00};
        de = mget(da);
        exp_rd_q.push_back(da);
        if (!de[0]) begin
          exp_rsp_q.push_back({2'b10, 32'h0});
          exp_tag_q.push_back("R5 directory fault");
        end else begin
          ta = {de[31:12], 12'h0} + {20'b0, req_vaddr[21:12], 2'b00};
          te = mget(ta);
          exp_rd_q.push_back(ta);
          if (!te[0]) begin
            exp_rsp_q.push_back({2'b11, 32'h0});
            exp_tag_q.push_back("R6 table fault");
          end else begin
            exp_rsp_q.push_back({2'b00, te[31:12], req_vaddr[11:0]});
            exp_tag_q.push_back("R4 translation");
          end
        end
      end
    end
  end

  // Memory and consumer responder
  bit          dly_on = 0;
  int          dly = 0;
  logic [31:0] dly_addr;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_data_valid = 1'b0;
    if (dly_on) begin
      if (dly == 0) begin
        mem_data_valid = 1'b1;
        mem_data = mget(dly_addr);
        dly_on = 0;
      end else dly--;
    end
    if (rd_fired) begin
      rd_fired = 0;
      dly_on = 1;
      dly_addr = rd_fired_addr;
      dly = lat_rand ? int'(lfsr[2:0]) : 0;
    end
    mem_rd_ready = !rd_stall || lfsr[0];
    rsp_ready    = !rsp_stall || lfsr[5];
  end

  task automatic issue(input logic [31:0] b, input logic [31:0] va, input bit flip);
    root_base = b;
    req_vaddr = va;
    req_valid = 1'b1;
    do begin @(posedge clk); #2; end while (!acc_flag);
    acc_flag  = 0;
    req_valid = 1'b0;
    req_vaddr = 32'hFFFF_FFFF;
    if (flip) root_base = 32'h00F0_0000;
  endtask

  task automatic drain();
    while (busy) begin @(posedge clk); #2; end
    repeat (3) @(posedge clk);
    #2;
  endtask

  function automatic logic [31:0] va(input int i1, input int i2, input int off);
    return {i1[9:0], i2[9:0], off[11:0]};
  endfunction

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  localparam logic [31:0] RA = 32'h0010_0000;
  localparam logic [31:0] RB = 32'h0030_0000;

  initial begin
    // Directory A
    pmem[RA + 32'd5*4]    = 32'h0020_0001;
    pmem[RA + 32'd1023*4] = 32'h0040_0001;
    pmem[RA + 32'd0]      = 32'h0060_0001;
    pmem[RA + 32'd9*4]    = 32'h0070_0000;   // invalid directory entry
    // Tables under A
    pmem[32'h0020_0000 + 32'd7*4]    = 32'h1234_5001;
    pmem[32'h0020_0000 + 32'd8*4]    = 32'h5555_5000; // invalid table entry
    pmem[32'h0020_0000 + 32'd300*4]  = 32'h0BEE_F003;
    pmem[32'h0040_0000 + 32'd1023*4] = 32'hFFFF_F001;
    pmem[32'h0060_0000]              = 32'h0000_1001;
    // Directory B with a different mapping for index 5
    pmem[RB + 32'd5*4]               = 32'h0050_0001;
    pmem[32'h0050_0000 + 32'd7*4]    = 32'h0ABC_D001;

    repeat (2) @(negedge clk);
    // R1: reset values
    check(req_ready == 1'b1, "R1 req_ready in reset", {33'b0, req_ready}, 34'h1);
    check(mem_rd_valid == 1'b0, "R1 mem_rd_valid in reset", {33'b0, mem_rd_valid}, 34'h0);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", {33'b0, rsp_valid}, 34'h0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && !mem_rd_valid && !rsp_valid, "R1 after release",
          {31'b0, req_ready, mem_rd_valid, rsp_valid}, 34'h4);
    @(posedge clk); #2;

    // R2 R3 R4: plain translations, no stalls
    issue(RA, va(5, 7, 12'hABC), 0);
    drain();
    issue(RA, va(5, 7, 0), 0);
    issue(RA, va(5, 7, 12'hFFF), 0);
    issue(RA, va(1023, 1023, 12'h123), 0);
    issue(RA, va(0, 0, 12'h456), 0);
    issue(RA, va(5, 300, 12'h001), 0);
    drain();

    // R5 R6: faults at each level
    issue(RA, va(9, 7, 12'h111), 0);
    issue(RA, va(5, 8, 12'h222), 0);
    issue(RA, va(77, 3, 12'h333), 0);
    drain();

    // R2: base sampled at acceptance, then moved mid-walk
    issue(RB, va(5, 7, 12'h777), 1);
    issue(RA, va(5, 7, 12'h888), 1);
    drain();

    // R7 R8 R9 R10: back-pressure on every side with random latency
    rd_stall = 1; rsp_stall = 1; lat_rand = 1;
    for (int k = 0; k < 40; k++) begin
      case (k % 6)
        0: issue(RA, va(5, 7, k * 37), k[0]);
        1: issue(RB, va(5, 7, k * 11), k[0]);
        2: issue(RA, va(9, k, k), k[0]);
        3: issue(RA, va(5, 8, k), k[0]);
        4: issue(RA, va(1023, 1023, k * 5), k[0]);
        default: issue(RA, va(0, 0, k), k[0]);
      endcase
    end
    drain();
    rd_stall = 0; rsp_stall = 0; lat_rand = 0;
    issue(RA, va(5, 7, 12'hDEF), 0);
    drain();

    check(exp_rd_q.size() == 0 && exp_rsp_q.size() == 0, "R10 all transactions retired",
          34'(exp_rd_q.size() + exp_rsp_q.size()), 34'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule